// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Arbiter

This block shares one single-ported memory bus among several masters. Ordinary accesses are granted in round-robin order, one transfer per grant. When a master needs an atomic update, it raises its lock input together with the read of that update. Once that read completes, the arbiter keeps the bus reserved for that master. Other masters are held off until the master finishes the matching write. The read and the write therefore cannot be split by another master's access, however long the master takes to compute the new value.

A transfer completes on a cycle in which the master is granted, still requests, and the memory raises its ready input. A master that is held off sees its grant stay low. It keeps its request asserted, and it is served once the reservation ends. The memory side carries a lock output, so downstream logic can see that an atomic sequence is in progress.

Top module: `lockArb`

## Requirements
- R1: At most one grant bit is high at any time. Grant bit i high means master i owns the bus. An idle arbiter raises the grant one cycle after it samples a request.
- R2: A grant stays high and keeps the same owner until that owner's transfer completes. A transfer completes when memReady is high while the owner is granted and requesting. The grant falls in the cycle after completion.
- R3: Unlocked arbitration is round-robin. After master k is granted, the search for the next grant starts at master k+1, wrapping to master 0 after the last master. After reset the search starts at master 0.
- R4: While a master is granted, the memory bus carries that master's address, write enable and write data. memReqOut equals the grant ANDed with that master's request. Read data from memory reaches every master on rdataOut.
- R5: A completed read (we low) with lock high opens a locked sequence. memLockOut is high during that read and stays high until the sequence ends.
- R6: During a locked sequence, no master other than the locking one is granted, however long the sequence lasts and whatever the other masters request.
- R7: A locked sequence ends in the cycle after the locking master completes a write with lock low. memLockOut is then low, and that write itself was granted ahead of any waiting master.
- R8: Masters that request during a locked sequence keep waiting without losing their turn. They are granted in round-robin order after the sequence ends.
- R9: A completed write from the locking master with lock still high does not end the sequence.
- R10: After reset no grant is high, memReqOut and memLockOut are low, and no sequence is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_MASTERS | Per-master request |
| lockIn | input | NUM_MASTERS | Per-master lock, raised with the read of an atomic update |
| weIn | input | NUM_MASTERS | Per-master write enable (1 = write) |
| addrIn | input | NUM_MASTERS*ADDR_W | Per-master address; master i in bits [i*ADDR_W +: ADDR_W] |
| wdataIn | input | NUM_MASTERS*DATA_W | Per-master write data; master i in bits [i*DATA_W +: DATA_W] |
| grantOut | output | NUM_MASTERS | Per-master grant |
| rdataOut | output | DATA_W | Read data, shared by all masters |
| memReqOut | output | 1 | Memory access request |
| memWeOut | output | 1 | Memory write enable |
| memAddrOut | output | ADDR_W | Memory address |
| memWdataOut | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data |
| memReady | input | 1 | Memory completes the current access |
| memLockOut | output | 1 | Bus lock, high during a locked sequence |

## Verification
A wrong lock flag shows up within one arbitration cycle. Either a blocked master's grant rises while memLockOut should still be high, or the bus stays reserved after the releasing write, so every waiting master starves. A corrupted owner or round-robin pointer shows up in the next grant. The wrong master is granted, or the memory bus carries the wrong master's address and data, in the cycle after the request is sampled. The bench therefore checks the order of grants and the lock output in every cycle of a long locked gap, not only at its ends.

// File: rtl/lockArbPkg.sv
package lockArbPkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             busValid;
    logic [SEL_W-1:0] sel;
  } pathCtrl_t;
endpackage

// File: rtl/lockArbCtrl.sv
module lockArbCtrl
  import lockArbPkg::*;
#(
  parameter int NUM_MASTERS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] lockIn,
  input  logic [NUM_MASTERS-1:0] weIn,
  input  logic                   memReady,
  output pathCtrl_t              ctl,
  output logic [NUM_MASTERS-1:0] grantOut,
  output logic                   memLockOut
);
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic             active;
  logic             locked;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] pick;
  logic [IDX_W-1:0] nextPtr;
  logic             anyReq;
  logic             xferDone;
  logic             ownerLockRd;
  logic             ownerPlainWr;

  // round-robin search starting at rrPtr; smallest offset wins
  always_comb begin
    anyReq = 1'b0;
    pick   = rrPtr;
    for (int k = NUM_MASTERS - 1; k >= 0; k--) begin
      int t;
      t = int'(rrPtr) + k;
      if (t >= NUM_MASTERS) t = t - NUM_MASTERS;
      if (reqIn[t]) begin
        anyReq = 1'b1;
        pick   = IDX_W'(t);
      end
    end
  end

  assign nextPtr      = (int'(pick) == NUM_MASTERS - 1) ? '0 : pick + 1'b1;
  assign xferDone     = active && memReady && reqIn[owner];
  assign ownerLockRd  = lockIn[owner] && !weIn[owner];
  assign ownerPlainWr = weIn[owner] && !lockIn[owner];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      locked <= 1'b0;
      owner  <= '0;
      rrPtr  <= '0;
    end else if (active) begin
      if (xferDone) begin
        active <= 1'b0;
        if (ownerLockRd)       locked <= 1'b1;
        else if (ownerPlainWr) locked <= 1'b0;
      end
    end else if (locked) begin
      if (reqIn[owner]) active <= 1'b1;
    end else if (anyReq) begin
      active <= 1'b1;
      owner  <= pick;
      rrPtr  <= nextPtr;
    end
  end

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : gGrant
    assign grantOut[i] = active && (owner == IDX_W'(i));
  end

  assign memLockOut   = locked || (active && lockIn[owner]);
  assign ctl.busValid = active;
  assign ctl.sel      = SEL_W'(owner);

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));

  assert_grant_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (active && !xferDone) |=> (active && $stable(owner)));

  assert_lock_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && ownerLockRd) |=> (locked && memLockOut));

  assert_lock_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(owner));

  assert_lock_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && ownerPlainWr) |=> !locked);

  assert_lock_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (locked && xferDone && lockIn[owner]) |=> locked);
endmodule

// File: rtl/lockArbPath.sv
module lockArbPath
  import lockArbPkg::*;
#(
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pathCtrl_t                     ctl,
  input  logic [NUM_MASTERS-1:0]        reqIn,
  input  logic [NUM_MASTERS-1:0]        weIn,
  input  logic [NUM_MASTERS*ADDR_W-1:0] addrIn,
  input  logic [NUM_MASTERS*DATA_W-1:0] wdataIn,
  input  logic [DATA_W-1:0]             memRdata,
  output logic                          memReqOut,
  output logic                          memWeOut,
  output logic [ADDR_W-1:0]             memAddrOut,
  output logic [DATA_W-1:0]             memWdataOut,
  output logic [DATA_W-1:0]             rdataOut
);
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic [ADDR_W-1:0] addrArr [NUM_MASTERS];
  logic [DATA_W-1:0] dataArr [NUM_MASTERS];
  logic [IDX_W-1:0]  sel;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : gUnpack
    assign addrArr[i] = addrIn[i*ADDR_W +: ADDR_W];
    assign dataArr[i] = wdataIn[i*DATA_W +: DATA_W];
  end

  assign sel = ctl.sel[IDX_W-1:0];

  always_comb begin
    memReqOut   = 1'b0;
    memWeOut    = 1'b0;
    memAddrOut  = '0;
    memWdataOut = '0;
    if (ctl.busValid) begin
      memReqOut   = reqIn[sel];
      memWeOut    = weIn[sel];
      memAddrOut  = addrArr[sel];
      memWdataOut = dataArr[sel];
    end
  end

  assign rdataOut = memRdata;

  assert_req_granted_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqOut |-> (ctl.busValid && reqIn[sel]));
endmodule

// File: rtl/lockArb.sv
module lockArb
  import lockArbPkg::*;
#(
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        reqIn,
  input  logic [NUM_MASTERS-1:0]        lockIn,
  input  logic [NUM_MASTERS-1:0]        weIn,
  input  logic [NUM_MASTERS*ADDR_W-1:0] addrIn,
  input  logic [NUM_MASTERS*DATA_W-1:0] wdataIn,
  output logic [NUM_MASTERS-1:0]        grantOut,
  output logic [DATA_W-1:0]             rdataOut,
  output logic                          memReqOut,
  output logic                          memWeOut,
  output logic [ADDR_W-1:0]             memAddrOut,
  output logic [DATA_W-1:0]             memWdataOut,
  input  logic [DATA_W-1:0]             memRdata,
  input  logic                          memReady,
  output logic                          memLockOut
);
  pathCtrl_t ctl;

  lockArbCtrl #(.NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .lockIn     (lockIn),
    .weIn       (weIn),
    .memReady   (memReady),
    .ctl        (ctl),
    .grantOut   (grantOut),
    .memLockOut (memLockOut)
  );

  lockArbPath #(.NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqIn       (reqIn),
    .weIn        (weIn),
    .addrIn      (addrIn),
    .wdataIn     (wdataIn),
    .memRdata    (memRdata),
    .memReqOut   (memReqOut),
    .memWeOut    (memWeOut),
    .memAddrOut  (memAddrOut),
    .memWdataOut (memWdataOut),
    .rdataOut    (rdataOut)
  );
endmodule

// File: tb/lockArb_tb.sv
module lockArb_tb;
  localparam int NM = 3;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [NM-1:0]    reqIn = '0;
  logic [NM-1:0]    lockIn = '0;
  logic [NM-1:0]    weIn = '0;
  logic [AW-1:0]    mAddr [NM];
  logic [DW-1:0]    mData [NM];
  logic [NM*AW-1:0] addrIn;
  logic [NM*DW-1:0] wdataIn;
  logic [NM-1:0]    grantOut;
  logic [DW-1:0]    rdataOut;
  logic             memReqOut, memWeOut, memLockOut;
  logic [AW-1:0]    memAddrOut;
  logic [DW-1:0]    memWdataOut;
  logic [DW-1:0]    memRdata;
  logic             memReady = 1'b1;
  logic [DW-1:0]    mem [256];

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      addrIn[i*AW +: AW]  = mAddr[i];
      wdataIn[i*DW +: DW] = mData[i];
    end
  end

  assign memRdata = mem[memAddrOut];
  always @(posedge clk)
    if (memReqOut && memWeOut && memReady) mem[memAddrOut] <= memWdataOut;

  lockArb #(.NUM_MASTERS(NM), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .lockIn(lockIn), .weIn(weIn),
    .addrIn(addrIn), .wdataIn(wdataIn), .grantOut(grantOut), .rdataOut(rdataOut),
    .memReqOut(memReqOut), .memWeOut(memWeOut), .memAddrOut(memAddrOut),
    .memWdataOut(memWdataOut), .memRdata(memRdata), .memReady(memReady),
    .memLockOut(memLockOut)
  );

  int total = 0;
  int bad = 0;
  int orderLog [64];
  int logLen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: record completed transfers, then drop the finished requests
  task automatic step();
    logic [NM-1:0] comp;
    @(posedge clk);
    comp = grantOut & reqIn & {NM{memReady}};
    for (int i = 0; i < NM; i++)
      if (comp[i]) begin
        orderLog[logLen] = i;
        logLen++;
      end
    @(negedge clk);
    reqIn = reqIn & ~comp;
  endtask

  task automatic waitLog(input int target);
    for (int n = 0; n < 40 && logLen < target; n++) step();
  endtask

  task automatic setM(input int m, input bit lk, input bit we, input int a, input int d);
    lockIn[m] = lk;
    weIn[m]   = we;
    mAddr[m]  = AW'(a);
    mData[m]  = DW'(d);
  endtask

  task automatic testReset();
    chk(grantOut == 0, "R10 grant after reset", grantOut, 0);
    chk(!memReqOut && !memLockOut, "R10 req/lock after reset", {memReqOut, memLockOut}, 0);
  endtask

  task automatic testSingle();
    setM(1, 0, 0, 5, 0);
    reqIn[1] = 1'b1;
    step();
    chk(grantOut == 3'b010, "R1 grant to master1", grantOut, 3'b010);
    chk(memReqOut && memAddrOut == 8'd5 && !memWeOut, "R4 bus carries master1 addr", memAddrOut, 5);
    chk(rdataOut == 16'h1005, "R4 read data", rdataOut, 16'h1005);
    step();
    chk(grantOut == 0, "R2 grant drops after completion", grantOut, 0);
  endtask

  task automatic testStall();
    int viol = 0;
    setM(0, 0, 0, 6, 0);
    memReady = 1'b0;
    reqIn[0] = 1'b1;
    step();
    for (int n = 0; n < 4; n++) begin
      if (grantOut != 3'b001) viol++;
      step();
    end
    chk(viol == 0 && grantOut == 3'b001, "R2 grant held while memory stalls", grantOut, 3'b001);
    memReady = 1'b1;
    step();
    chk(grantOut == 0, "R2 grant drops after stalled completion", grantOut, 0);
  endtask

  task automatic testRoundRobin();
    int base;
    base = logLen;
    setM(0, 0, 0, 1, 0);
    setM(1, 0, 0, 2, 0);
    setM(2, 0, 0, 3, 0);
    reqIn = 3'b111;
    waitLog(base + 3);
    // last grant was master0, so search starts at 1: order 1,2,0
    chk(orderLog[base] == 1 && orderLog[base+1] == 2 && orderLog[base+2] == 0,
        "R3 round-robin order", orderLog[base]*16 + orderLog[base+1]*4 + orderLog[base+2], 16+8+0);
  endtask

  task automatic testLockedRmw();
    int viol = 0;
    int base;
    logic [DW-1:0] oldVal;
    setM(0, 1, 0, 10, 0);
    reqIn[0] = 1'b1;
    step();
    chk(grantOut == 3'b001 && memLockOut, "R5 lock high during locked read", {grantOut, memLockOut}, 4'b0011);
    oldVal = rdataOut;
    step();
    chk(memLockOut && grantOut == 0, "R5 lock held after read", {grantOut, memLockOut}, 4'b0001);
    setM(1, 0, 0, 1, 0);
    setM(2, 0, 0, 2, 0);
    reqIn[1] = 1'b1;
    reqIn[2] = 1'b1;
    base = logLen;
    for (int n = 0; n < 12; n++) begin
      if (grantOut != 0 || !memLockOut) viol++;
      step();
    end
    chk(viol == 0 && logLen == base, "R6 others blocked during long gap", viol, 0);
    setM(0, 0, 1, 10, int'(oldVal) + 1);
    reqIn[0] = 1'b1;
    step();
    chk(grantOut == 3'b001, "R7 locking master granted for write", grantOut, 3'b001);
    step();
    chk(!memLockOut, "R7 lock released after write", memLockOut, 0);
    chk(mem[10] == 16'h100B, "R4 written value reaches memory", mem[10], 16'h100B);
    waitLog(base + 3);
    chk(orderLog[base+1] == 1 && orderLog[base+2] == 2, "R8 waiting masters served in order",
        orderLog[base+1]*4 + orderLog[base+2], 4+2);
  endtask

  task automatic testLockKeep();
    int viol = 0;
    int base;
    setM(2, 1, 0, 20, 0);
    reqIn[2] = 1'b1;
    step();
    step();
    setM(0, 0, 0, 3, 0);
    reqIn[0] = 1'b1;
    setM(2, 1, 1, 20, 16'h5555);
    reqIn[2] = 1'b1;
    step();
    chk(grantOut == 3'b100, "R6 owner granted over waiting master", grantOut, 3'b100);
    step();
    base = logLen;
    for (int n = 0; n < 3; n++) begin
      if (grantOut != 0 || !memLockOut) viol++;
      step();
    end
    chk(viol == 0 && logLen == base, "R9 locked write keeps sequence", viol, 0);
    setM(2, 0, 1, 20, 16'h6666);
    reqIn[2] = 1'b1;
    step();
    step();
    chk(!memLockOut && mem[20] == 16'h6666, "R7 release write stored", mem[20], 16'h6666);
    waitLog(base + 2);
    chk(logLen == base + 2 && orderLog[base+1] == 0, "R8 blocked master served after release",
        orderLog[base+1], 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(16'h1000 + i);
    for (int i = 0; i < NM; i++) begin
      mAddr[i] = '0;
      mData[i] = '0;
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testSingle();
    testStall();
    testRoundRobin();
    testLockedRmw();
    testLockKeep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule